// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block decides how a flash device reacts to its active-low reset pin. It samples the pin and a busy flag from the program/erase engine on every clock edge. From these it drives a deep-reset indication, an output-disable, a one-cycle abort strobe to the engine, and two registered qualifiers that say when a read and when a write may start. On every exit from reset it also pulses a load strobe, together with the values the mode, status and block-lock registers must take. All pulse, shutdown and recovery times are clock-cycle counts set by parameters.

When the engine is idle, a low pulse shorter than the minimum width is filtered out. A longer pulse puts the device into deep reset until the pin rises. When the pin falls while the engine is busy, the block aborts the operation and runs a shutdown phase of fixed length. At the end of that phase it goes into deep reset if the pin is still low. If the pin has already risen, it starts recovery at once. In that case the recovery delays count from the end of the shutdown phase. A new low sample during recovery sends the device straight back to deep reset. The chip-select input only gates the output drivers: deselecting the device never stops a running program or erase.

Top module: `flash_rst_seq`

## Requirements
- R1: While `por_n` is low and right after it is released, `deep_rst_o` is 1, `read_ok_o` and `write_ok_o` are 0, and `out_dis_o` is 1.
- R2: With `busy_i` low, `deep_rst_o` rises on the edge that samples the MIN_PULSE-th consecutive low level of `rst_pin_n`. A shorter low pulse leaves `deep_rst_o` and `init_load_o` at 0, and both qualifiers return to 1 on the first edge that samples the pin high again.
- R3: On every clock edge that samples `rst_pin_n` low, both `read_ok_o` and `write_ok_o` become 0 in that same edge.
- R4: After the edge on which the block leaves deep reset or shutdown, `read_ok_o` becomes 1 exactly READ_RECOV edges later and `write_ok_o` exactly WRITE_RECOV edges later. Both then stay 1 while the pin stays high.
- R5: On the exit edge, `init_load_o` is 1 for one cycle. At the same time `init_mode_o` is 0 (read-array mode), `init_status_o` is 8'h80, and every bit of `init_lock_o` is 1 (locked).
- R6: An edge that samples `rst_pin_n` low while `busy_i` is high raises `abort_o` for exactly one cycle. `deep_rst_o` stays 0 while the shutdown phase runs.
- R7: Shutdown ends on the SHUTDOWN_CYC-th edge after the abort edge. If the pin is high there, that edge is the exit edge of R4 and R5, whenever the pin rose. If the pin is low there, `deep_rst_o` becomes 1.
- R8: `chip_sel_n` high forces `out_dis_o` to 1 but never raises `abort_o` or `deep_rst_o` and leaves both qualifiers unchanged, even while `busy_i` is high.
- R9: `out_dis_o` is 1 exactly when `chip_sel_n` is 1 or `read_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Device reset pin, active low, sampled each edge |
| busy_i | input | 1 | Program or erase in progress |
| chip_sel_n | input | 1 | Chip select, active low |
| deep_rst_o | output | 1 | Device held in deep reset |
| out_dis_o | output | 1 | Output drivers disabled (high impedance) |
| abort_o | output | 1 | One-cycle strobe: abort the operation and mark its target invalid |
| read_ok_o | output | 1 | Read data may be driven |
| write_ok_o | output | 1 | A write may start |
| init_load_o | output | 1 | Load the reset values below into mode, status and locks |
| init_mode_o | output | 2 | Mode to load (0 = read array) |
| init_status_o | output | 8 | Status value to load |
| init_lock_o | output | NUM_BLOCKS | Lock bits to load, one per block |

## Verification
On every cycle, the checker confirms the following: the qualifiers drop after any low sample; an abort strobe lasts one cycle and only follows a busy, low-pin sample; deep reset never overlaps an abort or a load strobe; and reads are never enabled by an edge that saw the pin low. The exact recovery counts only show in the bench's scenarios. So do the difference between a shutdown that ends with the pin high or low, the recovery counted from the end of shutdown rather than from the pin's rise, the rejection of short pulses and the reset values. Random runs of short pulses and chip-select toggling check the pulse filter and the output-disable rule against expected values.

// File: rtl/flash_rst_pkg.sv
`timescale 1ns/1ps
package flash_rst_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_PULSE = 3'd1,
        ST_DEEP  = 3'd2,
        ST_SHUT  = 3'd3,
        ST_WAKE  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_CONFIG = 2'd1,
        MODE_STATUS = 2'd2,
        MODE_QUERY  = 2'd3
    } dev_mode_e;

    localparam logic [7:0] STATUS_AFTER_RESET = 8'h80;

endpackage

// File: rtl/flash_rst_defaults.sv
`timescale 1ns/1ps
module flash_rst_defaults
    import flash_rst_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    output logic [1:0]            mode_o,
    output logic [7:0]            status_o,
    output logic [NUM_BLOCKS-1:0] lock_o
);
    assign mode_o   = MODE_ARRAY;
    assign status_o = STATUS_AFTER_RESET;

    // every block comes out of reset locked
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
        assign lock_o[b] = 1'b1;
    end
endmodule

// File: rtl/flash_rst_seq.sv
`timescale 1ns/1ps
module flash_rst_seq
    import flash_rst_pkg::*;
#(
    parameter int MIN_PULSE    = 4,
    parameter int SHUTDOWN_CYC = 6,
    parameter int READ_RECOV   = 3,
    parameter int WRITE_RECOV  = 5,
    parameter int NUM_BLOCKS   = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_pin_n,
    input  logic                  busy_i,
    input  logic                  chip_sel_n,
    output logic                  deep_rst_o,
    output logic                  out_dis_o,
    output logic                  abort_o,
    output logic                  read_ok_o,
    output logic                  write_ok_o,
    output logic                  init_load_o,
    output logic [1:0]            init_mode_o,
    output logic [7:0]            init_status_o,
    output logic [NUM_BLOCKS-1:0] init_lock_o
);
    localparam int MAX_REC = (READ_RECOV > WRITE_RECOV) ? READ_RECOV : WRITE_RECOV;
    localparam int MAX_A   = (MIN_PULSE > SHUTDOWN_CYC) ? MIN_PULSE : SHUTDOWN_CYC;
    localparam int MAX_ALL = (MAX_A > MAX_REC) ? MAX_A : MAX_REC;
    localparam int CW      = $clog2(MAX_ALL + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          rd_ok;
        logic          wr_ok;
        logic          abort;
        logic          init;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.abort = 1'b0;
        seq_d.init  = 1'b0;
        if (!rst_pin_n) begin
            seq_d.rd_ok = 1'b0;
            seq_d.wr_ok = 1'b0;
        end
        unique case (seq_q.st)
            ST_RUN: begin
                if (!rst_pin_n) begin
                    if (busy_i) begin
                        seq_d.st    = ST_SHUT;
                        seq_d.cnt   = '0;
                        seq_d.abort = 1'b1;
                    end else if (MIN_PULSE <= 1) begin
                        seq_d.st = ST_DEEP;
                    end else begin
                        seq_d.st  = ST_PULSE;
                        seq_d.cnt = CW'(1);
                    end
                end
            end
            ST_PULSE: begin
                if (rst_pin_n) begin
                    seq_d.st    = ST_RUN;
                    seq_d.rd_ok = 1'b1;
                    seq_d.wr_ok = 1'b1;
                end else if (seq_q.cnt + CW'(1) >= CW'(MIN_PULSE)) begin
                    seq_d.st = ST_DEEP;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_DEEP: begin
                if (rst_pin_n) begin
                    seq_d.st   = ST_WAKE;
                    seq_d.cnt  = '0;
                    seq_d.init = 1'b1;
                end
            end
            ST_SHUT: begin
                if (seq_q.cnt == CW'(SHUTDOWN_CYC - 1)) begin
                    if (rst_pin_n) begin
                        seq_d.st   = ST_WAKE;
                        seq_d.cnt  = '0;
                        seq_d.init = 1'b1;
                    end else begin
                        seq_d.st = ST_DEEP;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_WAKE: begin
                if (!rst_pin_n) begin
                    seq_d.st = ST_DEEP;
                end else begin
                    if (seq_q.cnt != CW'(MAX_REC)) begin
                        seq_d.cnt = seq_q.cnt + CW'(1);
                    end
                    seq_d.rd_ok = (seq_d.cnt >= CW'(READ_RECOV));
                    seq_d.wr_ok = (seq_d.cnt >= CW'(WRITE_RECOV));
                    if (seq_d.cnt >= CW'(MAX_REC)) begin
                        seq_d.st = ST_RUN;
                    end
                end
            end
            default: seq_d.st = ST_DEEP;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_DEEP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign deep_rst_o  = (seq_q.st == ST_DEEP);
    assign out_dis_o   = chip_sel_n | ~seq_q.rd_ok;
    assign abort_o     = seq_q.abort;
    assign read_ok_o   = seq_q.rd_ok;
    assign write_ok_o  = seq_q.wr_ok;
    assign init_load_o = seq_q.init;

    flash_rst_defaults #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) i_defaults (
        .mode_o  (init_mode_o),
        .status_o(init_status_o),
        .lock_o  (init_lock_o)
    );
endmodule

// File: rtl/flash_rst_seq_chk.sv
`timescale 1ns/1ps
module flash_rst_seq_chk (
    input logic clk,
    input logic por_n,
    input logic rst_pin_n,
    input logic busy_i,
    input logic deep_rst_o,
    input logic out_dis_o,
    input logic abort_o,
    input logic read_ok_o,
    input logic write_ok_o,
    input logic init_load_o
);
    AST_LOW_DROPS_QUAL: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (!read_ok_o && !write_ok_o)); // R3
    AST_DEEP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        deep_rst_o |-> (out_dis_o && !write_ok_o && !read_ok_o)); // R2
    AST_READ_RISE_PIN_HIGH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(read_ok_o) |-> $past(rst_pin_n)); // R4
    AST_LOAD_OUTSIDE_DEEP: assert property (@(posedge clk) disable iff (!por_n)
        init_load_o |-> (!deep_rst_o && !read_ok_o)); // R5
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        abort_o |-> ($past(busy_i) && !$past(rst_pin_n))); // R6
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        abort_o |=> !abort_o); // R6
    AST_ABORT_NO_DEEP: assert property (@(posedge clk) disable iff (!por_n)
        abort_o |-> !deep_rst_o); // R6
endmodule

bind flash_rst_seq flash_rst_seq_chk i_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin_n  (rst_pin_n),
    .busy_i     (busy_i),
    .deep_rst_o (deep_rst_o),
    .out_dis_o  (out_dis_o),
    .abort_o    (abort_o),
    .read_ok_o  (read_ok_o),
    .write_ok_o (write_ok_o),
    .init_load_o(init_load_o)
);

// File: tb/test_flash_rst_seq.sv
`timescale 1ns/1ps
module test_flash_rst_seq;
    localparam int MIN_PULSE    = 4;
    localparam int SHUTDOWN_CYC = 6;
    localparam int READ_RECOV   = 3;
    localparam int WRITE_RECOV  = 5;
    localparam int NUM_BLOCKS   = 8;
    localparam int MAX_REC      = (READ_RECOV > WRITE_RECOV) ? READ_RECOV : WRITE_RECOV;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin_n = 1'b0;
    logic busy_i = 1'b0;
    logic chip_sel_n = 1'b0;
    logic deep_rst_o, out_dis_o, abort_o, read_ok_o, write_ok_o, init_load_o;
    logic [1:0] init_mode_o;
    logic [7:0] init_status_o;
    logic [NUM_BLOCKS-1:0] init_lock_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    flash_rst_seq #(
        .MIN_PULSE(MIN_PULSE), .SHUTDOWN_CYC(SHUTDOWN_CYC),
        .READ_RECOV(READ_RECOV), .WRITE_RECOV(WRITE_RECOV), .NUM_BLOCKS(NUM_BLOCKS)
    ) i_flash_rst_seq (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .busy_i(busy_i),
        .chip_sel_n(chip_sel_n), .deep_rst_o(deep_rst_o), .out_dis_o(out_dis_o),
        .abort_o(abort_o), .read_ok_o(read_ok_o), .write_ok_o(write_ok_o),
        .init_load_o(init_load_o), .init_mode_o(init_mode_o),
        .init_status_o(init_status_o), .init_lock_o(init_lock_o)
    );

    function automatic logic exp_out_dis(input logic cs_n, input logic rd);
        return cs_n | ~rd;
    endfunction

    function automatic logic exp_qual(input int edges, input int delay);
        return (edges >= delay);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // called right after the exit edge has been ticked
    task automatic check_exit_and_recover(input string tag);
        check({tag, " R5 load"}, init_load_o, 1);
        check("R5 mode", init_mode_o, 0);
        check("R5 status", init_status_o, 32'h80);
        check("R5 locks", init_lock_o, {NUM_BLOCKS{1'b1}});
        check({tag, " R4 rd at exit"}, read_ok_o, 0);
        for (int k = 1; k <= MAX_REC; k++) begin
            tick();
            check({tag, " R4 read_ok"}, read_ok_o, exp_qual(k, READ_RECOV));
            check({tag, " R4 write_ok"}, write_ok_o, exp_qual(k, WRITE_RECOV));
            check("R5 load one cycle", init_load_o, 0);
        end
        tick();
        check({tag, " R4 stays"}, read_ok_o & write_ok_o, 1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);

        // R1: power-on
        #20;
        check("R1 deep in por", deep_rst_o, 1);
        por_n = 1'b1;
        tick();
        check("R1 deep", deep_rst_o, 1);
        check("R1 read_ok", read_ok_o, 0);
        check("R1 write_ok", write_ok_o, 0);
        check("R1 out_dis", out_dis_o, 1);

        rst_pin_n = 1'b1;
        tick();
        check("R1 deep exit", deep_rst_o, 0);
        check_exit_and_recover("powerup");
        check("R9 enabled", out_dis_o, 0);

        // R2/R3: short pulse while idle is ignored
        rst_pin_n = 1'b0;
        tick();
        check("R3 read_ok drop", read_ok_o, 0);
        check("R3 write_ok drop", write_ok_o, 0);
        check("R9 dis on drop", out_dis_o, 1);
        for (int k = 2; k < MIN_PULSE; k++) begin
            tick();
            check("R2 short no deep", deep_rst_o, 0);
        end
        rst_pin_n = 1'b1;
        tick();
        check("R2 short restore rd", read_ok_o, 1);
        check("R2 short restore wr", write_ok_o, 1);
        check("R2 short no load", init_load_o, 0);
        check("R2 short deep", deep_rst_o, 0);

        // R2: long pulse enters deep reset
        rst_pin_n = 1'b0;
        for (int k = 1; k <= MIN_PULSE; k++) begin
            tick();
            check("R2 deep timing", deep_rst_o, (k == MIN_PULSE));
        end
        tick();
        check("R2 deep holds", deep_rst_o, 1);
        rst_pin_n = 1'b1;
        tick();
        check_exit_and_recover("long");

        // R6/R7: abort, pin released early
        busy_i = 1'b1;
        rst_pin_n = 1'b0;
        tick();
        check("R6 abort strobe", abort_o, 1);
        check("R6 no deep", deep_rst_o, 0);
        rst_pin_n = 1'b1;
        busy_i = 1'b0;
        for (int k = 1; k < SHUTDOWN_CYC; k++) begin
            tick();
            check("R6 abort one cycle", abort_o, 0);
            check("R7 no early load", init_load_o, 0);
            check("R7 no early read", read_ok_o, 0);
            check("R6 deep in shutdown", deep_rst_o, 0);
        end
        tick();
        check_exit_and_recover("R7 early release");

        // R7: abort, pin still low at end of shutdown
        busy_i = 1'b1;
        rst_pin_n = 1'b0;
        tick();
        check("R6 abort strobe 2", abort_o, 1);
        busy_i = 1'b0;
        for (int k = 1; k <= SHUTDOWN_CYC; k++) begin
            tick();
            check("R7 deep at end", deep_rst_o, (k == SHUTDOWN_CYC));
        end
        rst_pin_n = 1'b1;
        tick();
        check_exit_and_recover("R7 late release");

        // R8: deselect during busy
        chip_sel_n = 1'b1;
        busy_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R8 out_dis", out_dis_o, 1);
            check("R8 no abort", abort_o, 0);
            check("R8 no deep", deep_rst_o, 0);
            check("R8 read_ok kept", read_ok_o, 1);
            check("R8 write_ok kept", write_ok_o, 1);
        end
        busy_i = 1'b0;
        chip_sel_n = 1'b0;
        tick();
        check("R9 reselect", out_dis_o, 0);

        // random short pulses and select toggling
        for (int it = 0; it < 300; it++) begin
            int len;
            int gap;
            len = 1 + int'($urandom % (MIN_PULSE - 1));
            gap = 1 + int'($urandom % 6);
            rst_pin_n = 1'b0;
            for (int k = 0; k < len; k++) begin
                chip_sel_n = $urandom % 2;
                tick();
                check("R2 rand no deep", deep_rst_o, 0);
                check("R3 rand qual low", read_ok_o | write_ok_o, 0);
                check("R9 rand dis low", out_dis_o, exp_out_dis(chip_sel_n, 1'b0));
            end
            rst_pin_n = 1'b1;
            for (int k = 0; k < gap; k++) begin
                chip_sel_n = $urandom % 2;
                tick();
                check("R2 rand restore", read_ok_o & write_ok_o, 1);
                check("R2 rand no load", init_load_o, 0);
                check("R9 rand dis", out_dis_o, exp_out_dis(chip_sel_n, 1'b1));
            end
        end
        finish_run();
    end
endmodule